// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block turns single requests from an 8-bit controller core into timed cycles on an external memory bus. The low address byte and the data byte share one 8-bit port. Three kinds of cycle are supported: a code fetch, a data read and a data write. Each cycle opens with an address strobe so that a transparent latch outside the chip can hold the low address. A kind-specific strobe follows: a program-store enable for fetches, or a read or write strobe for data. Every interval is a whole number of oscillator clocks, and `clk` is that oscillator.

The core presents a request on a valid/ready handshake. It holds `req_valid` and the request fields stable until `req_ready` is seen high at a clock edge. The sequencer runs one cycle at a time. `req_ready` is low while a cycle is in flight, except in the final clock of that cycle. A request accepted in that final clock starts the next cycle with no idle gap. The response side has no back-pressure: `rsp_valid` is a one-clock done pulse, and the core must take `rsp_data` in that clock. The shared low port is exposed as separate output, output-enable and input signals, for a pad outside this block to combine.

Top module: `xbus_seq`

## Requirements
- R1: The address strobe `bus_ale` is high for exactly 2 clocks at the start of every cycle, and the low port drives `req_addr[7:0]` during those clocks.
- R2: The low address stays driven for at least 1 clock after `bus_ale` falls. It is driven until the strobe falls (fetch, read) or until write data takes over (write).
- R3: A fetch (`req_kind` = 2'b00) drives `bus_psen_n` low from 1 clock after `bus_ale` falls, for 3 clocks. The port byte is sampled in the last low clock and returned on `rsp_data`.
- R4: A read (`req_kind` = 2'b01) drives `bus_rd_n` low from 3 clocks after `bus_ale` falls, for 6 clocks. The low port is released in the clock where `bus_rd_n` falls, and the byte present in the last low clock is returned.
- R5: A write (`req_kind` = 2'b10) drives `bus_wr_n` low with the same timing as a read. `req_wdata` is driven on the low port from 1 clock before `bus_wr_n` falls until 1 clock after it rises.
- R6: `bus_ahi` carries `req_addr[15:8]` for the whole cycle. On a read or write with `req_hold_hi` = 1, it carries `hi_latch` instead. `req_hold_hi` has no effect on a fetch.
- R7: At most one of the three strobes is low at any time. `bus_psen_n` stays high during data cycles, and `bus_rd_n`/`bus_wr_n` stay high during fetches.
- R8: `rsp_valid` is high for exactly one clock per cycle: the clock after the strobe rises (7th clock of a fetch, 12th of a data cycle). `req_ready` is low in every other clock of a cycle.
- R9: A request accepted in the done clock raises `bus_ale` in the very next clock, which is 1 clock after the previous strobe returned high.
- R10: After reset and when idle, `bus_ale` = 0, all three strobes are high, `bus_alo_oe` = 0, `rsp_valid` = 0 and `req_ready` = 1. An asynchronous reset in mid-cycle returns the outputs to these levels at once.
- R11: `req_kind` = 2'b11 runs exactly as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all timing counts its periods |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write data byte |
| req_hold_hi | input | 1 | Data access: show `hi_latch` on the high port |
| hi_latch | input | 8 | Current high-port latch value |
| rsp_valid | output | 1 | One-clock done pulse |
| rsp_data | output | 8 | Byte read by a fetch or read |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_psen_n | output | 1 | Program-store enable, active low |
| bus_rd_n | output | 1 | Data read strobe, active low |
| bus_wr_n | output | 1 | Data write strobe, active low |
| bus_ahi | output | 8 | High address port |
| bus_alo_out | output | 8 | Low port drive value |
| bus_alo_oe | output | 1 | Low port output enable |
| bus_alo_in | input | 8 | Low port pad input |

## Verification
Two events can fall in the same clock: the done pulse of one cycle and the acceptance of the next request. The table of vectors is therefore run back to back. The bench presents the next request in the clock where `rsp_valid` is high and `req_ready` is expected high. In the following clock it requires `bus_ale` high and the new address on the low port, with the previous cycle's strobe already high for exactly one clock. The bus model drives the read byte only while a strobe is low and drives a filler value otherwise. This means a late sample, or a response that is corrupted by the overlapping start, shows up in `rsp_data`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    XK_FETCH    = 2'b00,
    XK_READ     = 2'b01,
    XK_WRITE    = 2'b10,
    XK_READ_ALT = 2'b11
  } xkind_e;
endpackage

// File: rtl/xbus_timer.sv
module xbus_timer #(
  parameter int CNT_W  = 4,
  parameter int F_LAST = 6,
  parameter int D_LAST = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_fetch,
  output logic             busy,
  output logic [CNT_W-1:0] tcnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] FL = CNT_W'(F_LAST);
  localparam logic [CNT_W-1:0] DL = CNT_W'(D_LAST);

  logic             busy_q;
  logic [CNT_W-1:0] t_q;

  assign busy = busy_q;
  assign tcnt = t_q;
  assign last = busy_q && (t_q == (is_fetch ? FL : DL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      t_q    <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      t_q    <= '0;
    end else if (last) begin
      busy_q <= 1'b0;
      t_q    <= '0;
    end else if (busy_q) begin
      t_q <= t_q + 1'b1;
    end
  end
endmodule

// File: rtl/xbus_strobes.sv
module xbus_strobes #(
  parameter int CNT_W     = 4,
  parameter int ALE_W     = 2,
  parameter int FETCH_DLY = 1,
  parameter int FETCH_W   = 3,
  parameter int DATA_DLY  = 3,
  parameter int DATA_W    = 6,
  parameter int WR_SETUP  = 1,
  parameter int WR_HOLD   = 1
) (
  input  logic             busy,
  input  logic [CNT_W-1:0] tcnt,
  input  logic             is_fetch,
  input  logic             is_write,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             addr_phase,
  output logic             data_phase,
  output logic             sample
);
  localparam int F_S = ALE_W + FETCH_DLY;
  localparam int F_E = F_S + FETCH_W;
  localparam int D_S = ALE_W + DATA_DLY;
  localparam int D_E = D_S + DATA_W;
  localparam int W_S = D_S - WR_SETUP;
  localparam int W_E = D_E + WR_HOLD;

  localparam logic [CNT_W-1:0] C_ALE = CNT_W'(ALE_W);
  localparam logic [CNT_W-1:0] C_FS  = CNT_W'(F_S);
  localparam logic [CNT_W-1:0] C_FE  = CNT_W'(F_E);
  localparam logic [CNT_W-1:0] C_DS  = CNT_W'(D_S);
  localparam logic [CNT_W-1:0] C_DE  = CNT_W'(D_E);
  localparam logic [CNT_W-1:0] C_WS  = CNT_W'(W_S);
  localparam logic [CNT_W-1:0] C_WE  = CNT_W'(W_E);
  localparam logic [CNT_W-1:0] C_FSM = CNT_W'(F_E - 1);
  localparam logic [CNT_W-1:0] C_DSM = CNT_W'(D_E - 1);

  logic in_fetch_win, in_data_win, in_wdata_win;

  assign in_fetch_win = (tcnt >= C_FS) && (tcnt < C_FE);
  assign in_data_win  = (tcnt >= C_DS) && (tcnt < C_DE);
  assign in_wdata_win = (tcnt >= C_WS) && (tcnt < C_WE);

  assign ale    = busy && (tcnt < C_ALE);
  assign psen_n = !(busy && is_fetch && in_fetch_win);
  assign rd_n   = !(busy && !is_fetch && !is_write && in_data_win);
  assign wr_n   = !(busy && is_write && in_data_win);

  always_comb begin
    addr_phase = 1'b0;
    if (busy) begin
      if (is_fetch)      addr_phase = (tcnt < C_FS);
      else if (is_write) addr_phase = (tcnt < C_WS);
      else               addr_phase = (tcnt < C_DS);
    end
  end

  assign data_phase = busy && is_write && in_wdata_win;
  assign sample     = busy && !is_write && (tcnt == (is_fetch ? C_FSM : C_DSM));
endmodule

// File: rtl/xbus_lowport.sv
module xbus_lowport #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] addr_lo,
  input  logic [DW-1:0] wdata,
  input  logic          addr_phase,
  input  logic          data_phase,
  input  logic          sample,
  input  logic [DW-1:0] pad_in,
  output logic [DW-1:0] pad_out,
  output logic          pad_oe,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rdata_q;

  assign pad_out = addr_phase ? addr_lo : wdata;
  assign pad_oe  = addr_phase || data_phase;
  assign rdata   = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (sample) rdata_q <= pad_in;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int ALE_W     = 2,
  parameter int FETCH_DLY = 1,
  parameter int FETCH_W   = 3,
  parameter int DATA_DLY  = 3,
  parameter int DATA_W    = 6,
  parameter int WR_SETUP  = 1,
  parameter int WR_HOLD   = 1,
  parameter int GAP       = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_hold_hi,
  input  logic [AW-DW-1:0] hi_latch,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          bus_ale,
  output logic          bus_psen_n,
  output logic          bus_rd_n,
  output logic          bus_wr_n,
  output logic [AW-DW-1:0] bus_ahi,
  output logic [DW-1:0] bus_alo_out,
  output logic          bus_alo_oe,
  input  logic [DW-1:0] bus_alo_in
);
  localparam int HW     = AW - DW;
  localparam int F_LAST = ALE_W + FETCH_DLY + FETCH_W + GAP - 1;
  localparam int D_LAST = ALE_W + DATA_DLY + DATA_W + GAP - 1;
  localparam int MAX_L  = (F_LAST > D_LAST) ? F_LAST : D_LAST;
  localparam int CNT_W  = $clog2(MAX_L + 1);

  xkind_e        kind_q;
  logic [DW-1:0] alo_q, wdata_q;
  logic [HW-1:0] hi_q;
  logic          busy, last, start, is_fetch, is_write;
  logic          addr_phase, data_phase, sample;
  logic [CNT_W-1:0] tcnt;

  assign req_ready = !busy || last;
  assign start     = req_valid && req_ready;
  assign is_fetch  = (kind_q == XK_FETCH);
  assign is_write  = (kind_q == XK_WRITE);
  assign rsp_valid = last;
  assign bus_ahi   = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= XK_FETCH;
      alo_q   <= '0;
      wdata_q <= '0;
      hi_q    <= '0;
    end else if (start) begin
      kind_q  <= xkind_e'(req_kind);
      alo_q   <= req_addr[DW-1:0];
      wdata_q <= req_wdata;
      if (req_hold_hi && (xkind_e'(req_kind) != XK_FETCH)) hi_q <= hi_latch;
      else                                                  hi_q <= req_addr[AW-1:DW];
    end
  end

  xbus_timer #(
    .CNT_W(CNT_W), .F_LAST(F_LAST), .D_LAST(D_LAST)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .is_fetch(is_fetch),
    .busy(busy), .tcnt(tcnt), .last(last)
  );

  xbus_strobes #(
    .CNT_W(CNT_W), .ALE_W(ALE_W), .FETCH_DLY(FETCH_DLY), .FETCH_W(FETCH_W),
    .DATA_DLY(DATA_DLY), .DATA_W(DATA_W), .WR_SETUP(WR_SETUP), .WR_HOLD(WR_HOLD)
  ) u_strobes (
    .busy(busy), .tcnt(tcnt), .is_fetch(is_fetch), .is_write(is_write),
    .ale(bus_ale), .psen_n(bus_psen_n), .rd_n(bus_rd_n), .wr_n(bus_wr_n),
    .addr_phase(addr_phase), .data_phase(data_phase), .sample(sample)
  );

  xbus_lowport #(.DW(DW)) u_lowport (
    .clk(clk), .rst_n(rst_n), .addr_lo(alo_q), .wdata(wdata_q),
    .addr_phase(addr_phase), .data_phase(data_phase), .sample(sample),
    .pad_in(bus_alo_in), .pad_out(bus_alo_out), .pad_oe(bus_alo_oe),
    .rdata(rsp_data)
  );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
  parameter int ALE_W   = 2,
  parameter int FETCH_W = 3,
  parameter int DATA_W  = 6
) (
  input logic clk,
  input logic rst_n,
  input logic bus_ale,
  input logic bus_psen_n,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_alo_oe,
  input logic rsp_valid,
  input logic req_ready
);
  logic [7:0] ale_cnt, psen_cnt, rd_cnt, wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_cnt <= '0; psen_cnt <= '0; rd_cnt <= '0; wr_cnt <= '0;
    end else begin
      ale_cnt  <= bus_ale     ? ale_cnt + 1'b1  : '0;
      psen_cnt <= !bus_psen_n ? psen_cnt + 1'b1 : '0;
      rd_cnt   <= !bus_rd_n   ? rd_cnt + 1'b1   : '0;
      wr_cnt   <= !bus_wr_n   ? wr_cnt + 1'b1   : '0;
    end
  end

  AST_ALE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ale) |-> ale_cnt == 8'(ALE_W)); // R1
  AST_FETCH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_psen_n) |-> psen_cnt == 8'(FETCH_W)); // R3
  AST_RD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd_n) |-> rd_cnt == 8'(DATA_W)); // R4
  AST_RD_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_alo_oe); // R4
  AST_WR_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> wr_cnt == 8'(DATA_W)); // R5
  AST_WR_DATA_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> bus_alo_oe && $past(bus_alo_oe)); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!bus_psen_n, !bus_rd_n, !bus_wr_n}) <= 1); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R8
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R8
  AST_ALE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_rd_n) || $rose(bus_wr_n) || $rose(bus_psen_n)) |-> !bus_ale); // R9
endmodule

bind xbus_seq xbus_seq_chk #(
  .ALE_W(ALE_W), .FETCH_W(FETCH_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ale(bus_ale), .bus_psen_n(bus_psen_n),
  .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_alo_oe(bus_alo_oe),
  .rsp_valid(rsp_valid), .req_ready(req_ready)
);

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_hold_hi = 1'b0;
  logic [7:0]  hi_latch = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic        bus_ale, bus_psen_n, bus_rd_n, bus_wr_n, bus_alo_oe;
  logic [7:0]  bus_ahi, bus_alo_out, bus_alo_in;
  logic [7:0]  cur_rdata = 8'h00;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // bus model: byte visible only while a read-type strobe is low
  assign bus_alo_in = (!bus_rd_n || !bus_psen_n) ? cur_rdata : 8'hEE;

  xbus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_hold_hi(req_hold_hi), .hi_latch(hi_latch), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .bus_ale(bus_ale), .bus_psen_n(bus_psen_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ahi(bus_ahi),
    .bus_alo_out(bus_alo_out), .bus_alo_oe(bus_alo_oe), .bus_alo_in(bus_alo_in)
  );

  // {kind[42:41], addr[40:25], wdata[24:17], hold[16], latch[15:8], rdata[7:0]}
  localparam int NV = 7;
  localparam logic [42:0] VEC [NV] = '{
    {2'b00, 16'h1234, 8'h00, 1'b1, 8'h77, 8'hA5},
    {2'b01, 16'hBEEF, 8'h00, 1'b0, 8'h00, 8'h3C},
    {2'b10, 16'h00FF, 8'h5A, 1'b0, 8'h00, 8'h00},
    {2'b01, 16'h4321, 8'h00, 1'b1, 8'hC3, 8'h96},
    {2'b10, 16'h8001, 8'h81, 1'b1, 8'h0F, 8'h00},
    {2'b11, 16'h7E7E, 8'h00, 1'b0, 8'h00, 8'hE1},
    {2'b00, 16'hFFFF, 8'h00, 1'b0, 8'h00, 8'h00}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic put(input logic [42:0] v);
    req_kind    = v[42:41];
    req_addr    = v[40:25];
    req_wdata   = v[24:17];
    req_hold_hi = v[16];
    hi_latch    = v[15:8];
    req_valid   = 1'b1;
  endtask

  task automatic check_idle(input string req);
    chk(bus_ale == 1'b0, req, "idle ale", bus_ale, 0);
    chk({bus_psen_n, bus_rd_n, bus_wr_n} == 3'b111, req, "idle strobes",
        {bus_psen_n, bus_rd_n, bus_wr_n}, 3'b111);
    chk(bus_alo_oe == 1'b0, req, "idle oe", bus_alo_oe, 0);
    chk(rsp_valid == 1'b0, req, "idle done", rsp_valid, 0);
    chk(req_ready == 1'b1, req, "idle ready", req_ready, 1);
  endtask

  // follows one accepted cycle clock by clock; optionally presents the next
  task automatic follow(input logic [42:0] v, input bit have_next, input logic [42:0] nv);
    logic [1:0]  k  = v[42:41];
    logic [15:0] a  = v[40:25];
    logic [7:0]  wd = v[24:17];
    bit          hh = v[16];
    logic [7:0]  hl = v[15:8];
    bit isf = (k == 2'b00);
    bit isw = (k == 2'b10);
    bit isr = !isf && !isw;
    int last = isf ? 6 : 11;
    string rtag = (k == 2'b11) ? "R11" : "R4";
    logic [7:0] exp_hi = (!isf && hh) ? hl : a[15:8];
    cur_rdata = v[7:0];
    for (int t = 0; t <= last; t++) begin
      bit e_ale, e_psen, e_rd, e_wr, aw, dw;
      @(negedge clk);
      if (t == 0) req_valid = 1'b0;
      e_ale  = (t < 2);
      e_psen = !(isf && t >= 3 && t <= 5);
      e_rd   = !(isr && t >= 5 && t <= 10);
      e_wr   = !(isw && t >= 5 && t <= 10);
      aw     = isf ? (t < 3) : (isw ? (t < 4) : (t < 5));
      dw     = isw && t >= 4 && t <= 11;
      chk(bus_ale == e_ale, (t < 2) ? "R1" : "R9", "ale", bus_ale, e_ale);
      chk(bus_psen_n == e_psen, isf ? "R3" : "R7", "psen_n", bus_psen_n, e_psen);
      chk(bus_rd_n == e_rd, isr ? rtag : "R7", "rd_n", bus_rd_n, e_rd);
      chk(bus_wr_n == e_wr, isw ? "R5" : "R7", "wr_n", bus_wr_n, e_wr);
      chk(bus_alo_oe == (aw || dw), (t == 2) ? "R2" : (isr ? "R4" : "R5"), "oe",
          bus_alo_oe, aw || dw);
      if (aw) chk(bus_alo_out == a[7:0], (t < 2) ? "R1" : "R2", "low addr",
                  bus_alo_out, a[7:0]);
      if (dw) chk(bus_alo_out == wd, "R5", "write data", bus_alo_out, wd);
      chk(bus_ahi == exp_hi, "R6", "high addr", bus_ahi, exp_hi);
      chk(rsp_valid == (t == last), "R8", "done", rsp_valid, t == last);
      chk(req_ready == (t == last), "R8", "ready", req_ready, t == last);
      if (t == last && !isw)
        chk(rsp_data == v[7:0], isf ? "R3" : rtag, "read data", rsp_data, v[7:0]);
      if (t == last && have_next) put(nv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R10");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R10");
    chk(bus_ahi == 8'h00, "R10", "reset high addr", bus_ahi, 0);

    // table walk, every cycle started in the done clock of the previous (R9)
    put(VEC[0]);
    for (int i = 0; i < NV; i++)
      follow(VEC[i], i < NV - 1, (i < NV - 1) ? VEC[i + 1] : VEC[i]);

    // return to idle after the last cycle
    @(negedge clk);
    check_idle("R10");

    // isolated write after idle clocks, then reset in mid-strobe (R10)
    repeat (2) @(negedge clk);
    check_idle("R10");
    put({2'b10, 16'h55AA, 8'h3E, 1'b0, 8'h00, 8'h00});
    @(negedge clk);
    req_valid = 1'b0;
    repeat (6) @(negedge clk);
    chk(bus_wr_n == 1'b0, "R5", "wr_n mid strobe", bus_wr_n, 0);
    rst_n = 1'b0;
    #1;
    check_idle("R10");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R10");

    // read with hold flag off after reset, gap before it
    put({2'b01, 16'hA0B0, 8'h00, 1'b0, 8'h99, 8'h6D});
    follow({2'b01, 16'hA0B0, 8'h00, 1'b0, 8'h99, 8'h6D}, 1'b0, '0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule